// File: doc/BRIEF.md
# GPIO Interrupt Detect and Latch Unit

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Each pin owns its own channel. The channel resynchronises the pin into the clock domain and looks for the condition chosen in its configuration register. That condition can be a rising edge, a falling edge, either edge, or a high or low level. When a match occurs, the channel records it in a sticky status bit.

Two enables act separately. The latch enable decides whether a match is recorded at all. The interrupt enable decides whether a recorded match reaches the summary output. As a result, a masked edge pin can still collect events. Each pin also has a three-bit target field that names one summary output line, one per processor. Each summary line is the OR of every pin that is routed to it and has both status and enable set.

Software reaches each pin's configuration, status and target registers through a simple write port and a combinational read port. It acknowledges an interrupt by writing the status register. A build parameter picks whether a 1 or a 0 clears the bit. A second build parameter selects a narrow one-bit detection field, which supports one edge direction at a time.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration, status and target register reads 0 and every summary output is low.
- R2: Register addresses are {pin index, kind}, where kind is 0 for configuration, 1 for status and 2 for target. Configuration bits are [0] interrupt enable, [1] latch enable, [2] polarity and [4:3] detect. With the wide field, detect code 1 and polarity 1 latch status on a 0-to-1 input change only.
- R3: With the wide field, detect code 2 latches on 1-to-0 changes only, and code 3 latches on changes in either direction.
- R4: With the wide field, detect code 0 is level mode. Polarity 1 is active-high and polarity 0 is active-low. While the active level persists, status is set again in the cycle after an acknowledge.
- R5: With the latch enable clear, no input activity sets the status bit (status read bit [0]).
- R6: With latch enable set and interrupt enable clear, events still set status while the summary stays low. Setting the interrupt enable afterwards raises the summary.
- R7: Writing status bit [0] with the acknowledge value (1 when ACK_HIGH=1, 0 when ACK_HIGH=0) clears the status. Writing the other value leaves it unchanged.
- R8: When a detected event and an acknowledge fall in the same cycle, status stays set.
- R9: A pin drives only the summary line whose index equals its target field [2:0]. A target of NUM_TARGETS or more drives no line.
- R10: Each summary line stays high while any pin routed to it has status and enable set, and falls once the last such pin is acknowledged.
- R11: With the narrow field (DET_WIDTH=1), detect bit [3] = 1 selects edge mode, where polarity 1 means rising and polarity 0 means falling. Bit [3] = 0 selects level mode.
- R12: A pin change that is stable before clock edge k shows on the summary output after edge k+2 and not before. This covers two synchroniser stages plus the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | NUM_PINS | Raw pin inputs, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | log2(NUM_PINS)+2 | Write address {pin, kind} |
| wr_data | input | 5 | Write data |
| rd_addr | input | log2(NUM_PINS)+2 | Read address {pin, kind} |
| rd_data | output | 5 | Combinational read data |
| irq_o | output | NUM_TARGETS | Summary interrupt, one line per target |

## Verification
The bench probes the cycle where an acknowledge meets a fresh event. A design that gives the acknowledge priority would lose that event, and status would read 0. It acknowledges a level pin while the level is still present. A design that forgot to re-latch would show status 0 one cycle later. It also times the summary rise to the exact edge, which exposes an extra or a missing pipeline stage.

The routing checks use a target value outside the supported range, and they keep one line shared by two pins. A decoder that truncates the target field, or a summary that drops on the first acknowledge, would be caught. A second instance built with the narrow detection field and zero-clears acknowledge checks that a rising change is ignored under falling polarity, and that writing 1 does not clear status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W = 5;
    localparam int TGT_W = 3;

    typedef enum logic [1:0] {
        KIND_CFG  = 2'd0,
        KIND_STAT = 2'd1,
        KIND_TGT  = 2'd2
    } reg_kind_e;

    // packed MSB first: detect[4:3], polarity[2], latch enable[1], irq enable[0]
    typedef struct packed {
        logic [1:0] detect;
        logic       pol;
        logic       latch_en;
        logic       irq_en;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t         cfg;
        logic             stat;
        logic [TGT_W-1:0] tgt;
        logic             prev;
    } chan_state_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] smp_o
);

    typedef struct packed {
        logic [N-1:0] stage2;
        logic [N-1:0] stage1;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = pin_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign smp_o = sync_q.stage2;

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
    import gpio_irq_pkg::*;
#(
    parameter int DET_WIDTH = 2,
    parameter bit ACK_HIGH  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic             cfg_we,
    input  logic             stat_we,
    input  logic             tgt_we,
    input  logic [CFG_W-1:0] wdata,
    output pin_cfg_t         cfg_o,
    output logic             stat_o,
    output logic [TGT_W-1:0] tgt_o
);

    chan_state_t state_d, state_q;
    logic rise, fall, lvl, hit, ack;

    assign rise = smp & ~state_q.prev;
    assign fall = ~smp & state_q.prev;
    assign lvl  = (smp == state_q.cfg.pol);
    assign ack  = stat_we && (wdata[0] == ACK_HIGH);

    generate
        if (DET_WIDTH == 2) begin : g_wide
            always_comb begin
                case (state_q.cfg.detect)
                    2'd0:    hit = lvl;
                    2'd1:    hit = rise;
                    2'd2:    hit = fall;
                    default: hit = rise | fall;
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                if (state_q.cfg.detect[0]) hit = state_q.cfg.pol ? rise : fall;
                else                       hit = lvl;
            end
        end
    endgenerate

    always_comb begin
        state_d      = state_q;
        state_d.prev = smp;
        if (cfg_we) state_d.cfg = pin_cfg_t'(wdata);
        if (tgt_we) state_d.tgt = wdata[TGT_W-1:0];
        if (hit && state_q.cfg.latch_en) state_d.stat = 1'b1;
        else if (ack)                    state_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cfg_o  = state_q.cfg;
    assign stat_o = state_q.stat;
    assign tgt_o  = state_q.tgt;

    p_latch_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.cfg.latch_en && !state_q.stat) |=> !state_q.stat);

    p_event_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && state_q.cfg.latch_en) |=> state_q.stat);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(hit && state_q.cfg.latch_en)) |=> !state_q.stat);

    p_set_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.stat |=> (!state_q.stat || $past(hit && state_q.cfg.latch_en)));

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int NUM_TARGETS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       stat_i,
    input  logic [NUM_PINS-1:0]       en_i,
    input  logic [NUM_PINS*TGT_W-1:0] tgt_i,
    output logic [NUM_TARGETS-1:0]    irq_o
);

    logic [NUM_PINS-1:0] live;
    assign live = stat_i & en_i;

    generate
        for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_tgt
            always_comb begin
                irq_o[t] = 1'b0;
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (live[p] && (tgt_i[p*TGT_W +: TGT_W] == TGT_W'(t)))
                        irq_o[t] = 1'b1;
                end
            end
        end
    endgenerate

    p_summary_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> (irq_o == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int NUM_TARGETS = 4,
    parameter int DET_WIDTH   = 2,
    parameter bit ACK_HIGH    = 1'b1,
    localparam int PIN_W      = $clog2(NUM_PINS),
    localparam int ADDR_W     = PIN_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    gpio_i,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CFG_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CFG_W-1:0]       rd_data,
    output logic [NUM_TARGETS-1:0] irq_o
);

    logic [NUM_PINS-1:0]       smp;
    logic [NUM_PINS-1:0]       stat_v;
    logic [NUM_PINS-1:0]       en_v;
    logic [NUM_PINS*TGT_W-1:0] tgt_flat;
    pin_cfg_t                  cfg_arr [NUM_PINS];
    reg_kind_e                 wr_kind;

    assign wr_kind = reg_kind_e'(wr_addr[1:0]);

    gpio_irq_sync #(.N(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (gpio_i),
        .smp_o (smp)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic sel;
            assign sel = wr_en && (wr_addr[ADDR_W-1:2] == PIN_W'(i));

            gpio_irq_chan #(.DET_WIDTH(DET_WIDTH), .ACK_HIGH(ACK_HIGH)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .smp     (smp[i]),
                .cfg_we  (sel && (wr_kind == KIND_CFG)),
                .stat_we (sel && (wr_kind == KIND_STAT)),
                .tgt_we  (sel && (wr_kind == KIND_TGT)),
                .wdata   (wr_data),
                .cfg_o   (cfg_arr[i]),
                .stat_o  (stat_v[i]),
                .tgt_o   (tgt_flat[i*TGT_W +: TGT_W])
            );

            assign en_v[i] = cfg_arr[i].irq_en;
        end
    endgenerate

    gpio_irq_route #(.NUM_PINS(NUM_PINS), .NUM_TARGETS(NUM_TARGETS)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_v),
        .en_i   (en_v),
        .tgt_i  (tgt_flat),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_addr[ADDR_W-1:2] == PIN_W'(i)) begin
                case (reg_kind_e'(rd_addr[1:0]))
                    KIND_CFG:  rd_data = cfg_arr[i];
                    KIND_STAT: rd_data = CFG_W'(stat_v[i]);
                    KIND_TGT:  rd_data = CFG_W'(tgt_flat[i*TGT_W +: TGT_W]);
                    default:   rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;

    localparam int NP = 8;
    localparam int NT = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [NP-1:0] gpio = '0;
    logic          wr_en = 1'b0, wr_en_l = 1'b0;
    logic [AW-1:0] wr_addr = '0, wr_addr_l = '0;
    logic [4:0]    wr_data = '0, wr_data_l = '0;
    logic [AW-1:0] rd_addr = '0, rd_addr_l = '0;
    logic [4:0]    rd_data, rd_data_l;
    logic [NT-1:0] irq, irq_l;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_unit #(.NUM_PINS(NP), .NUM_TARGETS(NT), .DET_WIDTH(2), .ACK_HIGH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
    );

    gpio_irq_unit #(.NUM_PINS(NP), .NUM_TARGETS(NT), .DET_WIDTH(1), .ACK_HIGH(1'b0)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .wr_en(wr_en_l), .wr_addr(wr_addr_l),
        .wr_data(wr_data_l), .rd_addr(rd_addr_l), .rd_data(rd_data_l), .irq_o(irq_l)
    );

    // {cfg[4:0], pin before, pin after, expected status}
    localparam logic [7:0] VEC [12] = '{
        {5'h0F, 1'b0, 1'b1, 1'b1}, {5'h0F, 1'b1, 1'b0, 1'b0}, {5'h0F, 1'b1, 1'b1, 1'b0},
        {5'h17, 1'b1, 1'b0, 1'b1}, {5'h17, 1'b0, 1'b1, 1'b0},
        {5'h1F, 1'b0, 1'b1, 1'b1}, {5'h1F, 1'b1, 1'b0, 1'b1}, {5'h1F, 1'b0, 1'b0, 1'b0},
        {5'h07, 1'b0, 1'b0, 1'b0}, {5'h07, 1'b0, 1'b1, 1'b1},
        {5'h03, 1'b1, 1'b1, 1'b0}, {5'h03, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit leg, input int pin, input int kind, input int data);
        if (leg) begin
            wr_en_l = 1'b1; wr_addr_l = AW'({pin[2:0], kind[1:0]}); wr_data_l = data[4:0];
        end else begin
            wr_en = 1'b1; wr_addr = AW'({pin[2:0], kind[1:0]}); wr_data = data[4:0];
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        wr_en_l = 1'b0;
    endtask

    task automatic rd(input bit leg, input int pin, input int kind, output logic [4:0] v);
        if (leg) rd_addr_l = AW'({pin[2:0], kind[1:0]});
        else     rd_addr = AW'({pin[2:0], kind[1:0]});
        #1;
        v = leg ? rd_data_l : rd_data;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] v;
        string tag;
        #1 rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        rd(0, 0, 0, v); chk("R1 cfg pin0", v, 0);
        rd(0, 0, 1, v); chk("R1 status pin0", v, 0);
        rd(0, 7, 2, v); chk("R1 target pin7", v, 0);
        chk("R1 summary", irq, 0);

        // table of detect modes on pin 0
        for (int k = 0; k < 12; k++) begin
            logic [4:0] c;
            c = VEC[k][7:3];
            tag = (c[4:3] == 2'd1) ? "R2" : (c[4:3] == 2'd0) ? "R4" : "R3";
            wr(0, 0, 0, 0);
            wr(0, 0, 1, 1);
            gpio[0] = VEC[k][2];
            settle(4);
            wr(0, 0, 0, int'(c));
            gpio[0] = VEC[k][1];
            settle(4);
            rd(0, 0, 1, v);
            chk($sformatf("%s vec%0d status", tag, k), v, 5'(VEC[k][0]));
            chk($sformatf("%s vec%0d summary", tag, k), irq[0], VEC[k][0]);
        end

        // R5 latch disabled
        wr(0, 0, 0, 0); wr(0, 0, 1, 1); gpio[0] = 0; settle(4);
        wr(0, 0, 0, 5'h0D); gpio[0] = 1; settle(4);
        rd(0, 0, 1, v); chk("R5 status", v, 0);
        chk("R5 summary", irq, 0);

        // R6 masked pin keeps latching
        wr(0, 0, 0, 5'h0E); gpio[0] = 0; settle(4);
        gpio[0] = 1; settle(4);
        rd(0, 0, 1, v); chk("R6 status while masked", v, 1);
        chk("R6 summary masked", irq, 0);
        wr(0, 0, 0, 5'h0F); settle(1);
        chk("R6 summary after enable", irq, 4'b0001);

        // R7 acknowledge polarity
        wr(0, 0, 1, 0); rd(0, 0, 1, v); chk("R7 write 0 keeps", v, 1);
        wr(0, 0, 1, 1); rd(0, 0, 1, v); chk("R7 write 1 clears", v, 0);
        chk("R7 summary cleared", irq, 0);

        // R4 level re-latch
        wr(0, 0, 0, 5'h07); gpio[0] = 1; settle(4);
        wr(0, 0, 1, 1); settle(1);
        rd(0, 0, 1, v); chk("R4 relatch", v, 1);
        gpio[0] = 0; settle(4);
        wr(0, 0, 1, 1); settle(1);
        rd(0, 0, 1, v); chk("R4 gone after level drops", v, 0);

        // R8 event and ack in same cycle
        wr(0, 0, 0, 5'h0F); settle(4); wr(0, 0, 1, 1);
        gpio[0] = 1;
        repeat (2) @(posedge clk);
        #1;
        wr(0, 0, 1, 1);
        rd(0, 0, 1, v); chk("R8 event wins", v, 1);

        // R12 latency
        wr(0, 0, 0, 5'h0F); gpio[0] = 0; settle(4); wr(0, 0, 1, 1); settle(1);
        gpio[0] = 1;
        repeat (2) @(posedge clk);
        #1 chk("R12 not before third edge", irq[0], 1'b0);
        @(posedge clk);
        #1 chk("R12 at third edge", irq[0], 1'b1);

        // R9 target routing
        wr(0, 0, 0, 0); wr(0, 0, 1, 1);
        wr(0, 1, 2, 2); wr(0, 1, 0, 5'h0F); gpio[1] = 0; settle(4);
        gpio[1] = 1; settle(4);
        chk("R9 routed to line 2", irq, 4'b0100);
        wr(0, 1, 2, 5); settle(1);
        chk("R9 out-of-range target", irq, 0);
        rd(0, 1, 1, v); chk("R9 status kept", v, 1);

        // R10 shared line
        wr(0, 1, 2, 0);
        wr(0, 0, 0, 5'h0F); gpio[0] = 0; settle(4);
        gpio[0] = 1; settle(4);
        chk("R10 both pins", irq, 4'b0001);
        wr(0, 0, 1, 1); settle(1);
        chk("R10 one pin left", irq, 4'b0001);
        wr(0, 1, 1, 1); settle(1);
        chk("R10 all acked", irq, 0);

        // R11 narrow detect field, zero-clears acknowledge
        wr(1, 2, 0, 5'h0B); gpio[2] = 1; settle(4);
        wr(1, 2, 1, 0);
        gpio[2] = 0; settle(4);
        rd(1, 2, 1, v); chk("R11 falling latched", v, 1);
        chk("R11 summary", irq_l, 4'b0001);
        wr(1, 2, 1, 1); rd(1, 2, 1, v); chk("R7 legacy write 1 keeps", v, 1);
        wr(1, 2, 1, 0); rd(1, 2, 1, v); chk("R7 legacy write 0 clears", v, 0);
        gpio[2] = 1; settle(4);
        rd(1, 2, 1, v); chk("R11 rising ignored", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule